// File: doc/BRIEF.md
# Half-Duplex Late-Collision and Carrier-Extension Controller

This block sits beside a MAC transmit path. It counts every symbol the transmitter puts on the line for the current frame, and it decides what a collision indication means. In half duplex, a collision that arrives while the frame is still inside the collision window always asks for the frame to be sent again. The window is 64 bytes at 10/100 Mb/s and 512 bytes at 1000 Mb/s. A collision after the window is a late collision: it asks for a retransmission only when the late-retry enable is set. Otherwise the frame is reported as sent. In full duplex, collision indications are ignored.

At gigabit speed, a frame shorter than the programmed minimum collision distance is followed by carrier-extension symbols until the minimum byte count is reached. This rule applies in both duplex modes. Extension symbols are not data, but they count toward the collision window. When the frame, including any extension, ends, the block reports its fate with a single-cycle done-ok or done-abort pulse. A retry request pulse follows each collision that forces a retransmission.

Top module: `hdx_latecol_ctrl`

## Requirements
- R1: At 10/100 (`cfg_gig`=0), half duplex, a collision in a cycle where fewer than `WIN_SLOW` (64) symbols of the frame were already sent raises `retry_req`, whatever `cfg_late_retry` is.
- R2: At 1000 (`cfg_gig`=1), half duplex, the same rule holds with a window of `WIN_GIG` (512) symbols.
- R3: In half duplex, a collision after the window (at least the window count already sent) with `cfg_late_retry`=1 raises `retry_req`, and the frame ends with `done_abort`.
- R4: In half duplex, a late collision with `cfg_late_retry`=0 gives no `retry_req`, and the frame ends with `done_ok`.
- R5: With `cfg_full_dup`=1, `col_in` and `cfg_late_retry` have no effect: there is no `retry_req`, and every frame ends with `done_ok`.
- R6: At 1000 with a frame length L below `cfg_min_bytes` M, `ext_active` is high for exactly M-L cycles. It starts in the cycle after the last data byte.
- R7: The extension of R6 also happens in full duplex.
- R8: At 10/100, or when L ≥ M, `ext_active` stays low.
- R9: Extension cycles count toward the window. A collision during extension is early or late by the total count of data and extension symbols sent before it.
- R10: Exactly one of `done_ok`/`done_abort` pulses, for one cycle, in the cycle after the last data byte or after the last extension cycle. `retry_req` pulses once, in the cycle after the first forcing collision of a frame.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gig | input | 1 | 1 = 1000 Mb/s, 0 = 10/100 Mb/s |
| cfg_full_dup | input | 1 | 1 = full duplex |
| cfg_late_retry | input | 1 | Retransmit on late collision |
| cfg_min_bytes | input | MIN_W | Minimum collision distance in bytes |
| tx_byte_vld | input | 1 | One data byte is sent this cycle |
| tx_eof | input | 1 | With `tx_byte_vld`: this byte is the frame's last |
| col_in | input | 1 | Collision indication |
| retry_req | output | 1 | Pulse: retransmit this frame |
| done_ok | output | 1 | Pulse: frame complete, reported as sent |
| done_abort | output | 1 | Pulse: frame complete, to be retransmitted |
| ext_active | output | 1 | Carrier-extension symbol is sent this cycle |

## Verification
The assertions check four things on every cycle. The two done pulses never coincide. Extension is confined to gigabit and stays below the minimum count. A done pulse follows the end of every extension. No retry appears after a collision in full duplex. The bench shows, through its scenarios, where the window boundary lies at each speed and how the late-retry enable acts. It also shows that extension cycles count toward the window, and it measures the exact extension length and the cycle of each pulse. To do this it sweeps collision positions around the window edge and frame/minimum length pairs in both duplex modes.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic {ST_DATA = 1'b0, ST_EXT = 1'b1} hdx_st_e;
endpackage

// File: rtl/hdx_byte_ctr.sv
module hdx_byte_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt;
    if (clr)                      cnt_d = '0;
    else if (inc && (cnt != '1))  cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/hdx_col_judge.sv
module hdx_col_judge #(
  parameter int CNT_W    = 11,
  parameter int WIN_SLOW = 64,
  parameter int WIN_GIG  = 512
) (
  input  logic [CNT_W-1:0] sent,
  input  logic             gig,
  input  logic             full_dup,
  input  logic             late_en,
  input  logic             col,
  input  logic             in_frame,
  input  logic             already,
  output logic             late,
  output logic             retry_now
);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(WIN_SLOW);
  localparam logic [CNT_W-1:0] LIM_GIG  = CNT_W'(WIN_GIG);

  always_comb begin
    late      = sent >= (gig ? LIM_GIG : LIM_SLOW);
    retry_now = col && in_frame && !full_dup && !already && (!late || late_en);
  end
endmodule

// File: rtl/hdx_latecol_ctrl.sv
module hdx_latecol_ctrl
  import hdx_pkg::*;
#(
  parameter int MIN_W    = 10,
  parameter int WIN_SLOW = 64,
  parameter int WIN_GIG  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_gig,
  input  logic             cfg_full_dup,
  input  logic             cfg_late_retry,
  input  logic [MIN_W-1:0] cfg_min_bytes,
  input  logic             tx_byte_vld,
  input  logic             tx_eof,
  input  logic             col_in,
  output logic             retry_req,
  output logic             done_ok,
  output logic             done_abort,
  output logic             ext_active
);
  localparam int CNT_W = MIN_W + 1;

  logic [1:0]       rst_sync;
  logic             rst_q;
  hdx_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, len_now, min_ext;
  logic             flag_q, flag_d;
  logic             frame_end, need_ext, ext_last, finish;
  logic             in_frame, cnt_inc, late, retry_now, abort_eff;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  hdx_byte_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk(clk), .rst_n(rst_q), .clr(finish), .inc(cnt_inc), .cnt(cnt_q)
  );

  hdx_col_judge #(.CNT_W(CNT_W), .WIN_SLOW(WIN_SLOW), .WIN_GIG(WIN_GIG)) i_judge (
    .sent(cnt_q), .gig(cfg_gig), .full_dup(cfg_full_dup), .late_en(cfg_late_retry),
    .col(col_in), .in_frame(in_frame), .already(flag_q),
    .late(late), .retry_now(retry_now)
  );

  always_comb begin
    len_now   = cnt_q + 1'b1;
    min_ext   = {1'b0, cfg_min_bytes};
    in_frame  = (st_q == ST_EXT) || (cnt_q != '0) || tx_byte_vld;
    frame_end = (st_q == ST_DATA) && tx_byte_vld && tx_eof;
    need_ext  = cfg_gig && (len_now < min_ext);
    ext_last  = (st_q == ST_EXT) && (len_now >= min_ext);
    finish    = (frame_end && !need_ext) || ext_last;
    cnt_inc   = ((st_q == ST_DATA) && tx_byte_vld) || (st_q == ST_EXT);
    abort_eff = flag_q || retry_now;
    flag_d    = finish ? 1'b0 : abort_eff;
    st_d      = st_q;
    if (frame_end && need_ext) st_d = ST_EXT;
    else if (ext_last)         st_d = ST_DATA;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q       <= ST_DATA;
      flag_q     <= 1'b0;
      retry_req  <= 1'b0;
      done_ok    <= 1'b0;
      done_abort <= 1'b0;
    end else begin
      st_q       <= st_d;
      flag_q     <= flag_d;
      retry_req  <= retry_now;
      done_ok    <= finish && !abort_eff;
      done_abort <= finish && abort_eff;
    end
  end

  assign ext_active = (st_q == ST_EXT);

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    !(done_ok && done_abort)); // R10
  AST_FD_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_q)
    (col_in && cfg_full_dup) |=> !retry_req); // R5
  AST_EXT_GIG_ONLY: assert property (@(posedge clk) disable iff (!rst_q)
    ext_active |-> cfg_gig); // R8
  AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_q)
    ext_active |-> (cnt_q < min_ext)); // R6
  AST_EXT_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(ext_active) |-> (done_ok || done_abort)); // R10
endmodule

// File: tb/test_hdx_latecol_ctrl.sv
`timescale 1ns/1ps
module test_hdx_latecol_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_gig = 1'b0, cfg_full_dup = 1'b0, cfg_late_retry = 1'b0;
  logic [9:0] cfg_min_bytes = '0;
  logic tx_byte_vld = 1'b0, tx_eof = 1'b0, col_in = 1'b0;
  logic retry_req, done_ok, done_abort, ext_active;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdx_latecol_ctrl i_hdx_latecol_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_gig(cfg_gig), .cfg_full_dup(cfg_full_dup),
    .cfg_late_retry(cfg_late_retry), .cfg_min_bytes(cfg_min_bytes),
    .tx_byte_vld(tx_byte_vld), .tx_eof(tx_eof), .col_in(col_in),
    .retry_req(retry_req), .done_ok(done_ok), .done_abort(done_abort),
    .ext_active(ext_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input bit gig, input bit full, input bit en,
                           input int L, input int M, input int c);
    int E, W, ret_cnt, ret_at, ok_cnt, ab_cnt, done_at, ext_cnt, ext_first;
    bit exp_retry;
    string rtag, etag;
    E = (gig && L < M) ? M - L : 0;
    W = gig ? 512 : 64;
    @(negedge clk);
    cfg_gig = gig; cfg_full_dup = full; cfg_late_retry = en; cfg_min_bytes = 10'(M);
    tx_byte_vld = 0; tx_eof = 0; col_in = 0;
    repeat (2) @(negedge clk);
    ret_cnt = 0; ret_at = -1; ok_cnt = 0; ab_cnt = 0; done_at = -1;
    ext_cnt = 0; ext_first = -1;
    for (int k = 0; k <= L + E + 2; k++) begin
      if (retry_req) begin ret_cnt++; if (ret_at < 0) ret_at = k; end
      if (done_ok)    begin ok_cnt++; done_at = k; end
      if (done_abort) begin ab_cnt++; done_at = k; end
      if (ext_active) begin ext_cnt++; if (ext_first < 0) ext_first = k; end
      tx_byte_vld = (k < L);
      tx_eof      = (k == L - 1);
      col_in      = (k == c);
      @(negedge clk);
    end
    tx_byte_vld = 0; tx_eof = 0; col_in = 0;
    exp_retry = !full && (c >= 0) && (c < L + E) && ((c < W) || en);
    if (full)                   rtag = "R5";
    else if (E > 0 && c >= L)   rtag = "R9";
    else if (c >= W)            rtag = en ? "R3" : "R4";
    else                        rtag = gig ? "R2" : "R1";
    etag = (E > 0) ? (full ? "R7" : "R6") : "R8";
    chk({rtag, " retry count"}, ret_cnt, exp_retry ? 1 : 0);
    if (exp_retry) chk("R10 retry cycle", ret_at, c + 1);
    chk({rtag, " done_ok"}, ok_cnt, exp_retry ? 0 : 1);
    chk({rtag, " done_abort"}, ab_cnt, exp_retry ? 1 : 0);
    chk("R10 done cycle", done_at, L + E);
    chk({etag, " ext length"}, ext_cnt, E);
    if (E > 0) chk({etag, " ext start"}, ext_first, L);
  endtask

  initial begin
    int pos[6];
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pos[6];
    int L, M, E, W;
    repeat (3) @(negedge clk);
    chk("R11 reset retry_req", retry_req, 0);
    chk("R11 reset done_ok", done_ok, 0);
    chk("R11 reset done_abort", done_abort, 0);
    chk("R11 reset ext_active", ext_active, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle outputs", {retry_req, done_ok, done_abort, ext_active}, 0);
    // collision position sweep around the window edge
    for (int g = 0; g < 2; g++)
      for (int f = 0; f < 2; f++)
        for (int e = 0; e < 2; e++)
          for (int fr = 0; fr < (g ? 2 : 1); fr++) begin
            W = g ? 512 : 64;
            L = g ? (fr ? 100 : 540) : 80;
            M = g ? (fr ? 600 : 0) : 0;
            E = (g && L < M) ? M - L : 0;
            pos[0] = 0; pos[1] = W - 1; pos[2] = W;
            pos[3] = L + E - 1; pos[4] = L + E; pos[5] = -1;
            for (int p = 0; p < 6; p++)
              run_frame(g[0], f[0], e[0], L, M, pos[p]);
          end
    // extension sweep, no collision
    for (int g = 0; g < 2; g++)
      for (int f = 0; f < 2; f++)
        for (int l = 1; l <= 20; l++)
          for (int m = 0; m <= 20; m++)
            run_frame(g[0], f[0], 1'b0, l, m, -1);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule